// File: doc/BRIEF.md
# Multiplexed External Bus Byte-Lane Controller

This block drives a 16-bit external bus on which address and data share the same pins. Every bus cycle has two parts. In the first, the bus clock is low and the pins carry the address. In the second, the bus clock is high and the pins carry write data or are released so that a device can return read data. External logic latches the address on the bus clock. A low-byte strobe combined with address bit 0 selects which byte lanes take part. From these the block produces even-lane and odd-lane chip enables, an output enable and a write enable.

The internal side offers one access at a time: address, write data, word or byte size, direction, and a flag that marks the target as external. The block takes a request at the last clock of a high phase and signals this on `reqTaken`. When the bus is idle the bus clock toggles on every clock, so it runs at half the input clock rate. For external accesses the high phase can be lengthened by 0 to 3 extra clocks, set by a 2-bit field and gated by an enable bit. Internal accesses use the same bus cycle, but they never stretch it and never touch the bus pins.

Top module: `mux_bus_lane_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `eclkOut` is 1. `ceEven`, `ceOdd`, `oe`, `we`, `adOe` and `rdValid` are 0, `rwOut` is 1 and `lowStrobeN` is 1.
- R2: With no request pending, `eclkOut` changes value on every clock, and no low phase lasts longer than one clock.
- R3: In the address phase of an external access (`eclkOut` = 0), `adOe` is 1 and `adOut` equals the full request address.
- R4: Lane decode, where A0 is address bit 0 and the strobe is active when `lowStrobeN` = 0. A word at an even address enables both lanes with the strobe active. A byte at an even address enables only `ceEven` with the strobe inactive. Any access at an odd address enables only `ceOdd` with the strobe active. The lane enables hold through both phases of the access.
- R5: `rwOut` is 0 for the whole of an external write and 1 otherwise. In the write data phase, `adOut` carries the word unchanged for an even word. For any other access it carries the low data byte copied into both halves, so the odd lane sees it on bits 7:0 and the even lane on bits 15:8.
- R6: In the data phase of an external read, `adOe` is 0 and `oe` is 1. The bus is sampled at the last high clock. One clock later `rdValid` pulses for one cycle, and `rdData` holds the full bus for an even word, bits 15:8 zero-extended for an even byte, or bits 7:0 zero-extended for an odd address.
- R7: `oe` and `we` are asserted only while `eclkOut` is 1. `we` is asserted only during an external write, and `oe` only during an external read.
- R8: When `stretchEn` is 1, the high phase of an external access lasts 1 + `stretchSel` clocks.
- R9: When `stretchEn` is 0, the high phase lasts one clock whatever the value of `stretchSel`.
- R10: An internal access (`reqExternal` = 0) never stretches. It asserts no chip enable, `oe` or `we`, leaves `adOe` at 0 and `rwOut` at 1, and produces no `rdValid`.
- R11: `reqTaken` is asserted only in the last clock of a high phase while `reqValid` is 1, and the clock after it is an address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, twice the bus clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request present |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 16 | Write data (the byte sits in bits 7:0) |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqExternal | input | 1 | 1 = target is on the external bus |
| stretchEn | input | 1 | Enables high-phase stretching |
| stretchSel | input | 2 | Number of extra high clocks |
| reqTaken | output | 1 | Request accepted at this clock edge |
| adIn | input | 16 | Value sampled from the shared pins |
| adOut | output | 16 | Value driven onto the shared pins |
| adOe | output | 1 | Drive enable for the shared pins |
| eclkOut | output | 1 | Bus clock |
| rwOut | output | 1 | 1 = read, 0 = write |
| lowStrobeN | output | 1 | Low-byte strobe, active low |
| ceEven | output | 1 | Chip enable for bits 15:8 |
| ceOdd | output | 1 | Chip enable for bits 7:0 |
| oe | output | 1 | Output enable for external devices |
| we | output | 1 | Write enable for external devices |
| rdData | output | 16 | Read result |
| rdValid | output | 1 | Read result valid pulse |

## Verification
The bench uses the default parameters: a 16-bit bus and a 2-bit stretch field. With these, every stretch value from 0 to 3 can be reached, including the longest high phase of four clocks, and each A0 and size combination maps onto a real byte lane. A data pattern with different upper and lower bytes shows whether lane steering and zero extension are correct. A stretched access interrupted by reset shows that the block returns to its reset state in the middle of an access.

// File: rtl/mbl_pkg.sv
package mbl_pkg;
  // Strobes from the phase sequencer to the lane datapath
  typedef struct packed {
    logic takeReq;    // latch request fields at this edge
    logic dataPhase;  // bus clock high: data on the pins
    logic busExt;     // current cycle belongs to an external access
    logic curRead;    // current access is a read
    logic capture;    // sample read data at this edge
  } mblStrobes_t;
endpackage

// File: rtl/mbl_ctrl.sv
module mbl_ctrl
  import mbl_pkg::*;
#(
  parameter int STRETCH_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqExternal,
  input  logic                 reqRead,
  input  logic                 stretchEn,
  input  logic [STRETCH_W-1:0] stretchSel,
  output logic                 reqTaken,
  output logic                 eclkOut,
  output mblStrobes_t          strobes
);
  logic                 phaseHigh;
  logic [STRETCH_W-1:0] holdCnt;
  logic                 curActive;
  logic                 curExt;
  logic                 curRd;
  logic                 lastHigh;
  logic                 extActive;

  assign extActive = curActive & curExt;
  assign lastHigh  = phaseHigh & (holdCnt == '0);
  assign reqTaken  = lastHigh & reqValid;
  assign eclkOut   = phaseHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseHigh <= 1'b1;
      holdCnt   <= '0;
      curActive <= 1'b0;
      curExt    <= 1'b0;
      curRd     <= 1'b1;
    end else if (phaseHigh) begin
      if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end else begin
        phaseHigh <= 1'b0;
        curActive <= reqValid;
        curExt    <= reqValid & reqExternal;
        curRd     <= reqValid ? reqRead : 1'b1;
      end
    end else begin
      phaseHigh <= 1'b1;
      holdCnt   <= (extActive && stretchEn) ? stretchSel : '0;
    end
  end

  always_comb begin
    strobes.takeReq   = reqTaken;
    strobes.dataPhase = phaseHigh;
    strobes.busExt    = extActive;
    strobes.curRead   = curRd;
    strobes.capture   = lastHigh & extActive & curRd;
  end
endmodule

// File: rtl/mbl_datapath.sv
module mbl_datapath
  import mbl_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  mblStrobes_t      strobes,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic             reqWord,
  input  logic [BUS_W-1:0] adIn,
  output logic [BUS_W-1:0] adOut,
  output logic             adOe,
  output logic             ceEven,
  output logic             ceOdd,
  output logic             oe,
  output logic             we,
  output logic             rwOut,
  output logic             lowStrobeN,
  output logic [BUS_W-1:0] rdData,
  output logic             rdValid
);
  localparam int LANE_W = BUS_W / 2;

  logic [BUS_W-1:0] addrQ;
  logic [BUS_W-1:0] wdataQ;
  logic             wordQ;
  logic [BUS_W-1:0] rdDataQ;
  logic             rdValidQ;
  logic             addrOdd;
  logic             lowLane;
  logic             fullWord;
  logic [BUS_W-1:0] busData;
  logic [BUS_W-1:0] rdSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      wordQ  <= 1'b0;
    end else if (strobes.takeReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      wordQ  <= reqWord;
    end
  end

  assign addrOdd  = addrQ[0];
  assign lowLane  = wordQ | addrOdd;
  assign fullWord = wordQ & ~addrOdd;

  assign busData = fullWord ? wdataQ : {2{wdataQ[LANE_W-1:0]}};

  always_comb begin
    if (fullWord)      rdSel = adIn;
    else if (!addrOdd) rdSel = {{LANE_W{1'b0}}, adIn[BUS_W-1:LANE_W]};
    else               rdSel = {{LANE_W{1'b0}}, adIn[LANE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= strobes.capture;
      if (strobes.capture) rdDataQ <= rdSel;
    end
  end

  assign ceEven     = strobes.busExt & ~addrOdd;
  assign ceOdd      = strobes.busExt & lowLane;
  assign lowStrobeN = ~(strobes.busExt & lowLane);
  assign rwOut      = ~(strobes.busExt & ~strobes.curRead);
  assign oe         = strobes.busExt & strobes.dataPhase & strobes.curRead;
  assign we         = strobes.busExt & strobes.dataPhase & ~strobes.curRead;
  assign adOe       = strobes.busExt & (~strobes.dataPhase | ~strobes.curRead);
  assign adOut      = strobes.dataPhase ? busData : addrQ;
  assign rdData     = rdDataQ;
  assign rdValid    = rdValidQ;
endmodule

// File: rtl/mux_bus_lane_ctrl.sv
module mux_bus_lane_ctrl
  import mbl_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int STRETCH_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [BUS_W-1:0]     reqAddr,
  input  logic [BUS_W-1:0]     reqWdata,
  input  logic                 reqWord,
  input  logic                 reqRead,
  input  logic                 reqExternal,
  input  logic                 stretchEn,
  input  logic [STRETCH_W-1:0] stretchSel,
  output logic                 reqTaken,
  input  logic [BUS_W-1:0]     adIn,
  output logic [BUS_W-1:0]     adOut,
  output logic                 adOe,
  output logic                 eclkOut,
  output logic                 rwOut,
  output logic                 lowStrobeN,
  output logic                 ceEven,
  output logic                 ceOdd,
  output logic                 oe,
  output logic                 we,
  output logic [BUS_W-1:0]     rdData,
  output logic                 rdValid
);
  mblStrobes_t strobes;

  mbl_ctrl #(.STRETCH_W(STRETCH_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqExternal(reqExternal),
    .reqRead(reqRead), .stretchEn(stretchEn), .stretchSel(stretchSel),
    .reqTaken(reqTaken), .eclkOut(eclkOut), .strobes(strobes)
  );

  mbl_datapath #(.BUS_W(BUS_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqWord(reqWord), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .ceEven(ceEven), .ceOdd(ceOdd), .oe(oe), .we(we),
    .rwOut(rwOut), .lowStrobeN(lowStrobeN), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/mbl_checker.sv
module mbl_checker #(
  parameter int STRETCH_W = 2
) (
  input logic clk,
  input logic rstN,
  input logic eclkOut,
  input logic ceEven,
  input logic ceOdd,
  input logic oe,
  input logic we,
  input logic rwOut,
  input logic lowStrobeN,
  input logic rdValid,
  input logic reqTaken,
  input logic adOe
);
  localparam int RUN_W = STRETCH_W + 2;
  localparam logic [RUN_W-1:0] MAX_HIGH = RUN_W'(1 << STRETCH_W);

  logic [RUN_W-1:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        highRun <= '0;
    else if (eclkOut) highRun <= highRun + 1'b1;
    else              highRun <= '0;
  end

  assert_low_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    !eclkOut |=> eclkOut);
  assert_lane_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((ceEven || ceOdd) && lowStrobeN) |-> (ceEven && !ceOdd));
  assert_enable_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    (oe || we) |-> (ceEven || ceOdd));
  assert_write_dir_R5: assert property (@(posedge clk) disable iff (!rstN)
    we |-> (!rwOut && adOe));
  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    oe |-> (rwOut && !adOe));
  assert_rdvalid_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !eclkOut);
  assert_enable_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (oe || we) |-> eclkOut);
  assert_oe_we_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(oe && we));
  assert_stretch_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    eclkOut |-> (highRun < MAX_HIGH));
  assert_take_then_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqTaken |=> !eclkOut);
  assert_take_high_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqTaken |-> eclkOut);
endmodule

bind mux_bus_lane_ctrl mbl_checker #(.STRETCH_W(STRETCH_W)) uChk (
  .clk(clk), .rstN(rstN), .eclkOut(eclkOut), .ceEven(ceEven), .ceOdd(ceOdd),
  .oe(oe), .we(we), .rwOut(rwOut), .lowStrobeN(lowStrobeN),
  .rdValid(rdValid), .reqTaken(reqTaken), .adOe(adOe)
);

// File: tb/mux_bus_lane_ctrl_test.sv
module mux_bus_lane_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // addr, data, word, read, ext, sen, sel, lanes{even,odd}, strobeAct, high, bus, rd
  localparam logic [75:0] VEC [NVEC] = '{
    {16'h1234, 16'hABCD, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 2'b11, 1'b1, 3'd1, 16'hABCD, 16'h0000},
    {16'h2000, 16'h00C5, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'b10, 1'b0, 3'd1, 16'hC5C5, 16'h0000},
    {16'h2001, 16'h005A, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'b01, 1'b1, 3'd3, 16'h5A5A, 16'h0000},
    {16'h4000, 16'hBEEF, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 2'b11, 1'b1, 3'd2, 16'h0000, 16'hBEEF},
    {16'h4002, 16'h12A7, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 2'b10, 1'b0, 3'd4, 16'h0000, 16'h0012},
    {16'h4003, 16'h12A7, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 2'b01, 1'b1, 3'd1, 16'h0000, 16'h00A7},
    {16'h4005, 16'h9876, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'b01, 1'b1, 3'd1, 16'h0000, 16'h0076},
    {16'h0800, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 2'b00, 1'b0, 3'd1, 16'h0000, 16'h0000},
    {16'h0801, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 2'b00, 1'b0, 3'd1, 16'h0000, 16'h0000},
    {16'hFFFE, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'b11, 1'b1, 3'd1, 16'h0001, 16'h0000},
    {16'h3003, 16'h0F3C, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 2'b01, 1'b1, 3'd4, 16'h3C3C, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqWord = 1'b0;
  logic        reqRead = 1'b0;
  logic        reqExternal = 1'b0;
  logic        stretchEn = 1'b0;
  logic [1:0]  stretchSel = '0;
  logic        reqTaken;
  logic [15:0] adIn = '0;
  logic [15:0] adOut;
  logic        adOe, eclkOut, rwOut, lowStrobeN, ceEven, ceOdd, oe, we, rdValid;
  logic [15:0] rdData;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_lane_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqWord(reqWord), .reqRead(reqRead),
    .reqExternal(reqExternal), .stretchEn(stretchEn), .stretchSel(stretchSel),
    .reqTaken(reqTaken), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .eclkOut(eclkOut), .rwOut(rwOut), .lowStrobeN(lowStrobeN), .ceEven(ceEven),
    .ceOdd(ceOdd), .oe(oe), .we(we), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    logic [7:0] act;
    act = {eclkOut, ceEven, ceOdd, oe, we, adOe, rwOut, lowStrobeN};
    check(act == 8'b1000_0011 && !rdValid, req, {23'd0, rdValid, act}, 32'h83);
  endtask

  task automatic runVec(input logic [75:0] v);
    logic ext, rd, wr;
    int   hc;
    bit   earlyTake;
    ext = v[41];
    rd  = v[42];
    wr  = ext && !rd;
    @(negedge clk);
    reqAddr = v[75:60]; reqWdata = v[59:44]; reqWord = v[43]; reqRead = rd;
    reqExternal = ext; stretchEn = v[40]; stretchSel = v[39:38];
    adIn = v[59:44]; reqValid = 1'b1;
    earlyTake = 1'b0;
    for (int g = 0; g < 20 && !reqTaken; g++) begin
      @(negedge clk);
      if (reqTaken && !eclkOut) earlyTake = 1'b1;
    end
    check(!earlyTake && eclkOut, "R11 take only in high phase", {31'd0, earlyTake}, 0);
    @(negedge clk);
    reqValid = 1'b0;
    // address phase
    check(!eclkOut && (ext ? (adOe && adOut == v[75:60]) : !adOe),
          ext ? "R3 address phase" : "R10 internal no drive",
          {15'd0, adOe, adOut}, {16'd0, v[75:60]});
    check({ceEven, ceOdd} == v[37:36], ext ? "R4 lane enables" : "R10 no chip enable",
          {30'd0, ceEven, ceOdd}, {30'd0, v[37:36]});
    check(!lowStrobeN == v[35], "R4 low strobe", {31'd0, !lowStrobeN}, {31'd0, v[35]});
    check(rwOut == !wr, "R5 direction", {31'd0, rwOut}, {31'd0, !wr});
    @(negedge clk);
    // first data phase clock
    check(eclkOut && oe == (ext && rd) && we == wr,
          ext ? "R7 enables in data phase" : "R10 no enables",
          {29'd0, eclkOut, oe, we}, {29'd0, 1'b1, ext && rd, wr});
    if (wr)
      check(adOe && adOut == v[31:16], "R5 write data placement",
            {15'd0, adOe, adOut}, {16'd1, v[31:16]});
    else
      check(!adOe, ext ? "R6 read releases bus" : "R10 internal no drive",
            {31'd0, adOe}, 0);
    hc = 0;
    for (int g = 0; g < 20 && eclkOut; g++) begin
      check({ceEven, ceOdd} == v[37:36], "R4 lanes held", {30'd0, ceEven, ceOdd},
            {30'd0, v[37:36]});
      hc++;
      @(negedge clk);
    end
    check(hc == int'(v[34:32]),
          !ext ? "R10 internal no stretch" : (v[40] ? "R8 stretch length" : "R9 stretch disabled"),
          hc, {29'd0, v[34:32]});
    check(rdValid == (ext && rd) && (!(ext && rd) || rdData == v[15:0]),
          ext ? "R6 read capture" : "R10 no read result",
          {15'd0, rdValid, rdData}, {15'd0, ext && rd, v[15:0]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic prevE;
    repeat (3) @(negedge clk);
    checkIdle("R1 reset state");
    rstN = 1'b1;
    @(negedge clk);
    // R2: idle toggling
    prevE = eclkOut;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(eclkOut != prevE && !ceEven && !ceOdd, "R2 idle toggle",
            {30'd0, prevE, eclkOut}, {30'd0, prevE, !prevE});
      prevE = eclkOut;
    end
    for (int i = 0; i < NVEC; i++) runVec(VEC[i]);

    // Reset in the middle of a stretched external read
    @(negedge clk);
    reqAddr = 16'h5000; reqWord = 1'b1; reqRead = 1'b1; reqExternal = 1'b1;
    stretchEn = 1'b1; stretchSel = 2'd3; reqValid = 1'b1;
    for (int g = 0; g < 20 && !reqTaken; g++) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(oe && eclkOut, "R8 mid stretch before reset", {30'd0, oe, eclkOut}, 3);
    rstN = 1'b0;
    #1;
    checkIdle("R1 reset during access");
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkIdle("R1 first cycle after reset");
    runVec(VEC[0]);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule